// File: doc/BRIEF.md
# Pin Interrupt Routing Controller

This block gathers interrupt requests from several 16-bit GPIO ports into one 32-bit sense vector and drives a single interrupt line to a parent controller. Each port splits into a lower and an upper 8-bit half. A routing register picks, for each of the four byte lanes of the sense vector, which port feeds that lane. Lanes 0 and 2 take a port's lower half. Lanes 1 and 3 take its upper half. To map a whole port onto bits 15:0 or bits 31:16, software writes the same port code into both bytes of that half.

Every routed bit passes through a two-flop synchronizer and then an optional polarity inversion. Detection happens only when the inverted value is 1 (level mode) or when it goes from 0 to 1 (edge mode). Inverting a bit therefore gives falling-edge or active-low sensing. Detected events are held in a pending register that software clears by writing ones. The interrupt output is high while any pending bit is also enabled in the mask. Mask, invert and edge configuration each have a set address and a clear address, so software can change single bits without a read-modify-write.

Top module: `pin_irq_router`

## Requirements
- R1: After reset the mask, pending, invert, edge and routing registers all read 0, and `irq` is 0.
- R2: Byte k of the routing register (address 7) holds a port code c. Sense bits [8k+7:8k] take port c's pins [7:0] when k is 0 or 2, and its pins [15:8] when k is 1 or 3. Port c's pins are `port_pins[16c+15:16c]`. A code of `NPORTS` or more feeds zeros.
- R3: The set addresses (mask 0, invert 3, edge 5) set exactly the bits written as 1. The clear addresses (mask 1, invert 4, edge 6) clear exactly those bits. Bits written as 0 keep their value. Reads of 0/1, 3/4 and 5/6 return the mask, invert and edge registers respectively.
- R4: A bit with its edge flag at 1 and its invert flag at 0 becomes pending on the third rising clock edge after its pin rises, and not before.
- R5: With the invert flag at 1, an edge-mode bit becomes pending when its pin falls, not when it rises.
- R6: With the edge flag at 0, a bit is pending while its inverted input is 1. A write-one clear has no lasting effect while that holds. After the input drops, the bit stays pending until it is cleared.
- R7: Writing to address 2 clears exactly the pending bits written as 1. Reading address 2 returns the pending register.
- R8: If a detected edge and a write-one clear reach the same pending bit in the same cycle, the bit stays pending.
- R9: `irq` is 1 exactly when some bit is both pending and set in the mask. Bits in either 16-bit half raise it.
- R10: Changing an invert flag while its input is steady creates no pending event in edge mode.
- R11: In edge mode, an input that stays at 1 after its pending bit is cleared does not set the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | NPORTS*16 | GPIO port inputs, port p on bits [16p+15:16p] |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request to the parent controller |

## Verification
The assertions assume that a write is a single-cycle pulse of `bus_sel` and `bus_wr`, with address and data stable at the clock edge, and that at most one register changes per cycle. Pin inputs may change at any time. The assertions never reason about pin timing directly, only about the detect vector seen after synchronization. The bench drives pins and bus signals on the falling edge and reads half a cycle later, so every access falls cleanly on one rising edge. In the collision test it places the clear write on exactly the edge that latches the detected event.

// File: rtl/pin_irq_router.sv
`timescale 1ns/1ps
module pin_irq_router #(
  parameter int NPORTS = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORTS*2*LANE_W-1:0]  port_pins,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [4*LANE_W-1:0]         bus_wdata,
  output logic [4*LANE_W-1:0]         bus_rdata,
  output logic                        irq
);
  localparam int PORT_W  = 2 * LANE_W;
  localparam int SENSE_W = 4 * LANE_W;

  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ISET = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_ROUT = ADDR_W'(7);

  logic [SENSE_W-1:0] mask_r, pend_r, inv_r, edge_r, route_r;
  logic [SENSE_W-1:0] sense, sync1, sync2, sync3;
  logic [SENSE_W-1:0] pol_now, pol_prev, set_v;
  logic               wr;

  assign wr = bus_sel & bus_wr;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [LANE_W-1:0] lane;
    always_comb begin
      lane = '0;
      for (int p = 0; p < NPORTS; p++)
        if (route_r[k*LANE_W +: LANE_W] == LANE_W'(p))
          lane = port_pins[p*PORT_W + (k % 2)*LANE_W +: LANE_W];
    end
    assign sense[k*LANE_W +: LANE_W] = lane;
  end

  assign pol_now  = sync2 ^ inv_r;
  assign pol_prev = sync3 ^ inv_r;
  assign set_v    = (edge_r & pol_now & ~pol_prev) | (~edge_r & pol_now);

  function automatic logic [SENSE_W-1:0] wmask(input logic [ADDR_W-1:0] a);
    return (wr && bus_addr == a) ? bus_wdata : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= sense;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r  <= '0;
      inv_r   <= '0;
      edge_r  <= '0;
      pend_r  <= '0;
      route_r <= '0;
    end else begin
      mask_r <= (mask_r | wmask(A_MSET)) & ~wmask(A_MCLR);
      inv_r  <= (inv_r  | wmask(A_ISET)) & ~wmask(A_ICLR);
      edge_r <= (edge_r | wmask(A_ESET)) & ~wmask(A_ECLR);
      pend_r <= (pend_r & ~wmask(A_PEND)) | set_v;
      if (wr && bus_addr == A_ROUT) route_r <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MSET, A_MCLR: bus_rdata = mask_r;
      A_PEND:         bus_rdata = pend_r;
      A_ISET, A_ICLR: bus_rdata = inv_r;
      A_ESET, A_ECLR: bus_rdata = edge_r;
      A_ROUT:         bus_rdata = route_r;
      default:        bus_rdata = '0;
    endcase
  end

  assign irq = |(pend_r & mask_r);
endmodule

// File: rtl/pin_irq_router_chk.sv
`timescale 1ns/1ps
module pin_irq_router_chk #(
  parameter int W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      mask,
  input logic [W-1:0]      pend,
  input logic [W-1:0]      setv,
  input logic              irq
);
  // R3: mask set address
  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(0)) |=> ((mask & $past(wdata)) == $past(wdata)));

  // R3: mask clear address
  a_r3_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(1)) |=> ((mask & $past(wdata)) == '0));

  // R8: a detected event always lands in pending
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(setv)) == $past(setv)));

  // R7: pending bits rise only from a detected event
  a_r7_pend_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(setv)) == '0));

  // R9: interrupt needs a pending and enabled bit
  a_r9_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((mask != '0) && (pend != '0)));

  // R1: idle right after reset release
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == '0 && !irq));
endmodule

bind pin_irq_router pin_irq_router_chk #(.W(SENSE_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(bus_addr), .wdata(bus_wdata),
  .mask(mask_r), .pend(pend_r), .setv(set_v), .irq(irq)
);

// File: tb/test_pin_irq_router.sv
`timescale 1ns/1ps
module test_pin_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] port_pins = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  pin_irq_router i_pin_irq_router (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pins(int idx, logic v);
    @(negedge clk);
    port_pins[idx] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), d);
      chk("R1 register reset", d, 32'h0);
    end
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    pins(0, 1'b1); settle();
    rd_reg(3'd2, d); chk("R2 default route low lanes", d, 32'h0001_0001);
    pins(0, 1'b0); settle();
    wr_reg(3'd2, 32'hFFFF_FFFF);
    wr_reg(3'd7, 32'h0302_0100);
    rd_reg(3'd7, d); chk("R2 route readback", d, 32'h0302_0100);
    pins(24, 1'b1); pins(16, 1'b1); pins(33, 1'b1); settle();
    rd_reg(3'd2, d); chk("R2 upper half to lane1, lower to lane2", d, 32'h0002_0100);
    pins(24, 1'b0); pins(16, 1'b0); pins(33, 1'b0); settle();
    wr_reg(3'd2, 32'hFFFF_FFFF);
    wr_reg(3'd7, 32'h0702_0100);
    pins(56, 1'b1); settle();
    rd_reg(3'd2, d); chk("R2 out-of-range code feeds zero", d, 32'h0);
    wr_reg(3'd7, 32'h0302_0100); settle();
    rd_reg(3'd2, d); chk("R2 lane3 from port3 upper half", d, 32'h0100_0000);
    pins(56, 1'b0); settle();
    wr_reg(3'd2, 32'hFFFF_FFFF);
    rd_reg(3'd2, d); chk("R7 clear after level drop", d, 32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr_reg(3'd5, 32'hFFFF_FFFF);
    rd_reg(3'd5, d); chk("R3 edge set", d, 32'hFFFF_FFFF);
    wr_reg(3'd6, 32'h0000_FFFF);
    rd_reg(3'd6, d); chk("R3 edge clear partial", d, 32'hFFFF_0000);
    wr_reg(3'd5, 32'h0000_FFFF);
    wr_reg(3'd0, 32'h0000_F0F0);
    wr_reg(3'd0, 32'h0000_000F);
    rd_reg(3'd1, d); chk("R3 mask set keeps others", d, 32'h0000_F0FF);
    wr_reg(3'd1, 32'h0000_00F0);
    rd_reg(3'd0, d); chk("R3 mask clear only ones", d, 32'h0000_F00F);
    wr_reg(3'd1, 32'hFFFF_FFFF);
    wr_reg(3'd3, 32'h8000_0001);
    wr_reg(3'd3, 32'h0000_0100);
    rd_reg(3'd4, d); chk("R3 invert set", d, 32'h8000_0101);
    wr_reg(3'd4, 32'h8000_0001);
    rd_reg(3'd3, d); chk("R3 invert clear", d, 32'h0000_0100);
    wr_reg(3'd4, 32'hFFFF_FFFF); settle();
    rd_reg(3'd2, d); chk("R10 invert change no event", d, 32'h0);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    @(negedge clk); port_pins[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd_reg(3'd2, d); chk("R4 not pending after two edges", d, 32'h0);
    rd_reg(3'd2, d); chk("R4 pending after third edge", d, 32'h1);
    wr_reg(3'd2, 32'h1); settle();
    rd_reg(3'd2, d); chk("R11 steady high no retrigger", d, 32'h0);
    pins(0, 1'b0); settle();
    rd_reg(3'd2, d); chk("R4 falling ignored", d, 32'h0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    wr_reg(3'd3, 32'h2); settle();
    rd_reg(3'd2, d); chk("R10 invert on low input no event", d, 32'h0);
    pins(1, 1'b1); settle();
    rd_reg(3'd2, d); chk("R5 rise ignored when inverted", d, 32'h0);
    pins(1, 1'b0); settle();
    rd_reg(3'd2, d); chk("R5 fall detected", d, 32'h2);
    wr_reg(3'd4, 32'h2);
    wr_reg(3'd2, 32'h2);
    rd_reg(3'd2, d); chk("R7 cleared", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr_reg(3'd6, 32'h4);
    pins(2, 1'b1); settle();
    rd_reg(3'd2, d); chk("R6 level pending", d, 32'h4);
    wr_reg(3'd2, 32'h4);
    rd_reg(3'd2, d); chk("R6 clear ignored while active", d, 32'h4);
    pins(2, 1'b0); settle();
    rd_reg(3'd2, d); chk("R6 held after drop", d, 32'h4);
    wr_reg(3'd2, 32'h4);
    rd_reg(3'd2, d); chk("R6 cleared after drop", d, 32'h0);
    wr_reg(3'd5, 32'h4);
  endtask

  task automatic t_clear_only();
    logic [31:0] d;
    pins(0, 1'b1); pins(3, 1'b1); settle();
    wr_reg(3'd2, 32'h1);
    rd_reg(3'd2, d); chk("R7 clear only written bits", d, 32'h8);
    wr_reg(3'd2, 32'h8);
    pins(0, 1'b0); pins(3, 1'b0); settle();
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk); port_pins[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr_reg(3'd2, 32'h10);
    rd_reg(3'd2, d); chk("R8 event beats clear", d, 32'h10);
    wr_reg(3'd2, 32'h10);
    rd_reg(3'd2, d); chk("R8 later clear works", d, 32'h0);
    pins(4, 1'b0); settle();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pins(5, 1'b1); settle();
    chk("R9 masked pending no irq", {31'b0, irq}, 32'h0);
    wr_reg(3'd0, 32'h20);
    chk("R9 enabled pending irq", {31'b0, irq}, 32'h1);
    wr_reg(3'd1, 32'h20);
    chk("R9 masked again", {31'b0, irq}, 32'h0);
    wr_reg(3'd0, 32'h20);
    wr_reg(3'd2, 32'h20);
    chk("R9 cleared pending drops irq", {31'b0, irq}, 32'h0);
    pins(5, 1'b0);
    wr_reg(3'd0, 32'h0010_0000);
    pins(36, 1'b1); settle();
    chk("R9 high half raises irq", {31'b0, irq}, 32'h1);
    rd_reg(3'd2, d); chk("R9 high half pending bit", d, 32'h0010_0000);
    pins(36, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_route();
    t_setclr();
    t_rising();
    t_falling();
    t_level();
    t_clear_only();
    t_collision();
    t_irq();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule